// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sleep and Hardware Wake-Up

This block receives asynchronous serial characters on a single data-in line. Timing comes from an external tick that runs at sixteen times the bit rate. A character is a low start bit, then 8 or 9 data bits sent least significant bit first, then a stop bit. A mode input selects the 8-bit or 9-bit length. Each bit is decided by a three-sample majority vote taken near the middle of the bit. A completed character goes into a one-entry receive buffer, together with its noise and framing-error flags. The block also reports overrun when a character arrives while the buffer is still occupied, and raises an idle flag when the line has gone quiet after traffic.

In a multi-drop network, a receiver that is not being addressed can be put to sleep. While it sleeps, characters on the line are dropped without touching the buffer or its flags. The hardware wakes the receiver by itself, using one of two methods chosen by a select input:

- **Idle-line wake:** the line stays high for one full character time.
- **Address-mark wake:** a character arrives whose most significant data bit is 1. That waking character is kept.

While the block is disabled, all of its flags and its sleep state are held clear, and it releases the data-in pin.

Top module: `uart_wake_rx`

## Requirements
- R1: While `rx_en` is 0, the outputs `full`, `idle`, `overrun`, `noise`, `frame_err` and `sleeping` read 0 from the next clock edge onward. Characters on the line are ignored, and `wake_req` has no effect.
- R2: `pin_claim` is 1 exactly while `rx_en` is 1.
- R3: A one-cycle `wake_req` pulse with `rx_en` at 1 makes `sleeping` read 1 after the next clock edge.
- R4: When `wake_sel` is 0 and the block is asleep, `sleeping` clears once the line has been high for 10 bit times (160 ticks) with `len9`=0, or for 11 bit times (176 ticks) with `len9`=1. The count restarts at every low sample and at every `wake_req`. When `wake_sel` is 1, an idle line never wakes the block.
- R5: When `wake_sel` is 1 and the block is asleep, a character whose most significant data bit is 1 clears `sleeping` and is loaded into the buffer. That bit is bit 7 when `len9`=0 and bit 8 when `len9`=1. A character with that bit at 0 leaves the block asleep.
- R6: While asleep, every character other than the waking one in R5 leaves `full`, `rx_data` and the flags unchanged.
- R7: A character is a 0 start bit, then 8 data bits (`len9`=0) or 9 data bits (`len9`=1) sent least significant bit first, then a stop bit. When it is loaded, `rx_data` holds the data bits with bit 0 first received, bit 8 is 0 in 8-bit mode, and `full` reads 1.
- R8: Each bit is taken as the majority of the line at ticks 8, 9 and 10 after the bit edge. The start edge is found on a high-to-low change. `noise` is loaded as 1 when the three samples of any bit of the character disagree. A start bit whose vote is 1 is dropped without loading anything.
- R9: `frame_err` is loaded as 1 when the stop bit votes 0. A new start is recognised only after the line has returned high.
- R10: When a character completes while `full` is 1, `overrun` becomes 1. `rx_data`, `noise` and `frame_err` keep the older character's values.
- R11: A one-cycle `rd_ack` pulse clears `full`, `overrun`, `noise`, `frame_err` and `idle`.
- R12: After a start edge, once the line has been high for one character time as in R4 while awake, `idle` becomes 1. The next start edge clears it. It never rises while `sleeping` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit time |
| rx_in | input | 1 | Serial data-in line |
| rx_en | input | 1 | Receiver enable |
| wake_req | input | 1 | Pulse that puts the receiver to sleep |
| wake_sel | input | 1 | Wake method: 0 idle line, 1 address mark |
| len9 | input | 1 | Character length: 0 eight bits, 1 nine bits |
| rd_ack | input | 1 | Buffer taken; clears the buffer flags |
| pin_claim | output | 1 | Receiver owns the data-in pin |
| rx_data | output | 9 | Received character |
| full | output | 1 | Buffer holds an unread character |
| idle | output | 1 | Line idle after traffic |
| overrun | output | 1 | Character lost because the buffer was full |
| noise | output | 1 | Sample disagreement in the buffered character |
| frame_err | output | 1 | Stop bit of the buffered character read as 0 |
| sleeping | output | 1 | Receiver asleep, waiting for a wake-up |

## Verification
The bench builds the block with its default parameters: 8 base data bits and 16 ticks per bit. The tick is held high every cycle, so one bit lasts exactly 16 clocks. This puts a glitch in a single cycle at tick 9 of a bit in reach, which exercises the vote and the noise flag. It also makes the 160- and 176-tick wake thresholds measurable to within a few cycles on either side. Both character lengths and both wake methods are run, including the 9-bit address case where only bit 8 decides the wake-up.

// File: rtl/uart_wake_rx_pkg.sv
package uart_wake_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/rx_bit_voter.sv
module rx_bit_voter
    import uart_wake_rx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic run,
    input  logic line,
    output logic strobe,
    output logic bit_val,
    output logic noisy
);
    localparam int CW = $clog2(OS_RATE);
    localparam logic [CW-1:0] SMP_A = CW'(OS_RATE / 2 - 1);
    localparam logic [CW-1:0] SMP_B = CW'(OS_RATE / 2);
    localparam logic [CW-1:0] SMP_C = CW'(OS_RATE / 2 + 1);
    localparam logic [CW-1:0] LAST  = CW'(OS_RATE - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          s_a;
        logic          s_b;
    } vote_regs_t;

    vote_regs_t v_d, v_q;

    always_comb begin
        v_d = v_q;
        if (restart) begin
            v_d.cnt = CW'(1);
        end else if (run && tick) begin
            v_d.cnt = (v_q.cnt == LAST) ? '0 : v_q.cnt + CW'(1);
            if (v_q.cnt == SMP_A) v_d.s_a = line;
            if (v_q.cnt == SMP_B) v_d.s_b = line;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign strobe  = run && tick && !restart && (v_q.cnt == SMP_C);
    assign bit_val = maj3(v_q.s_a, v_q.s_b, line);
    assign noisy   = !((v_q.s_a == v_q.s_b) && (v_q.s_b == line));
endmodule

// File: rtl/rx_wake_ctrl.sv
module rx_wake_ctrl #(
    parameter int OS_RATE = 16,
    parameter int DATA_W  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic line,
    input  logic len9,
    input  logic wake_sel,
    input  logic wake_req,
    input  logic start_seen,
    input  logic frame_done,
    input  logic frame_msb,
    input  logic ack,
    output logic accept,
    output logic sleeping,
    output logic idle_flag
);
    localparam int LIM_SHORT = (DATA_W + 2) * OS_RATE;
    localparam int LIM_LONG  = (DATA_W + 3) * OS_RATE;
    localparam int CW        = $clog2(LIM_LONG + 1);

    typedef struct packed {
        logic [CW-1:0] run;
        logic          asleep;
        logic          armed;
        logic          idle;
    } wake_regs_t;

    wake_regs_t w_d, w_q;
    logic [CW-1:0] limit;
    logic          quiet_hit;
    logic          addr_wake;

    always_comb begin
        limit     = len9 ? CW'(LIM_LONG) : CW'(LIM_SHORT);
        quiet_hit = en && tick && line && !wake_req && (w_q.run == limit - CW'(1));
        addr_wake = w_q.asleep && wake_sel && frame_done && frame_msb;
        accept    = en && frame_done && (!w_q.asleep || addr_wake);

        w_d = w_q;
        if (!line || wake_req) begin
            w_d.run = '0;
        end else if (tick && (w_q.run < limit)) begin
            w_d.run = w_q.run + CW'(1);
        end

        if (wake_req) begin
            w_d.asleep = 1'b1;
        end else if (w_q.asleep && !wake_sel && quiet_hit) begin
            w_d.asleep = 1'b0;
        end else if (addr_wake) begin
            w_d.asleep = 1'b0;
        end

        if (start_seen) begin
            w_d.armed = 1'b1;
            w_d.idle  = 1'b0;
        end else if (quiet_hit && w_q.armed && !w_q.asleep) begin
            w_d.armed = 1'b0;
            w_d.idle  = 1'b1;
        end
        if (ack) w_d.idle = 1'b0;

        if (!en) w_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign sleeping  = w_q.asleep;
    assign idle_flag = w_q.idle;
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
    import uart_wake_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_in,
    input  logic              rx_en,
    input  logic              wake_req,
    input  logic              wake_sel,
    input  logic              len9,
    input  logic              rd_ack,
    output logic              pin_claim,
    output logic [DATA_W:0]   rx_data,
    output logic              full,
    output logic              idle,
    output logic              overrun,
    output logic              noise,
    output logic              frame_err,
    output logic              sleeping
);
    localparam int FW = DATA_W + 1;
    localparam int IW = $clog2(FW + 1);

    typedef struct packed {
        rx_state_e      state;
        logic [IW-1:0]  idx;
        logic [FW-1:0]  shreg;
        logic           nf;
        logic           prev;
        logic [FW-1:0]  data;
        logic           full;
        logic           ovr;
        logic           noise;
        logic           fe;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic          line;
    logic          restart, start_seen, frame_done, fe_now, nf_now;
    logic          v_strobe, v_bit, v_noisy;
    logic          accept;
    logic [IW-1:0] last_idx;
    logic [FW-1:0] frame_val;
    logic          frame_msb;

    rx_line_sync #(.STAGES(2)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_in),
        .dout  (line)
    );

    rx_bit_voter #(.OS_RATE(OS_RATE)) i_voter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .restart (restart),
        .run     (r_q.state != ST_IDLE),
        .line    (line),
        .strobe  (v_strobe),
        .bit_val (v_bit),
        .noisy   (v_noisy)
    );

    rx_wake_ctrl #(.OS_RATE(OS_RATE), .DATA_W(DATA_W)) i_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (rx_en),
        .tick       (os_tick),
        .line       (line),
        .len9       (len9),
        .wake_sel   (wake_sel),
        .wake_req   (wake_req),
        .start_seen (start_seen),
        .frame_done (frame_done),
        .frame_msb  (frame_msb),
        .ack        (rd_ack),
        .accept     (accept),
        .sleeping   (sleeping),
        .idle_flag  (idle)
    );

    always_comb begin
        last_idx  = len9 ? IW'(DATA_W) : IW'(DATA_W - 1);
        frame_val = len9 ? r_q.shreg : {1'b0, r_q.shreg[FW-1:1]};
        frame_msb = r_q.shreg[FW-1];

        r_d        = r_q;
        restart    = 1'b0;
        start_seen = 1'b0;
        frame_done = 1'b0;
        fe_now     = 1'b0;
        nf_now     = 1'b0;

        if (os_tick) r_d.prev = line;

        case (r_q.state)
            ST_IDLE: begin
                if (rx_en && os_tick && r_q.prev && !line) begin
                    r_d.state  = ST_START;
                    r_d.nf     = 1'b0;
                    restart    = 1'b1;
                    start_seen = 1'b1;
                end
            end
            ST_START: begin
                if (v_strobe) begin
                    if (v_bit) begin
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.state = ST_DATA;
                        r_d.idx   = '0;
                        r_d.nf    = v_noisy;
                    end
                end
            end
            ST_DATA: begin
                if (v_strobe) begin
                    r_d.shreg = {v_bit, r_q.shreg[FW-1:1]};
                    r_d.nf    = r_q.nf | v_noisy;
                    if (r_q.idx == last_idx) r_d.state = ST_STOP;
                    else                     r_d.idx   = r_q.idx + IW'(1);
                end
            end
            ST_STOP: begin
                if (v_strobe) begin
                    frame_done = 1'b1;
                    fe_now     = !v_bit;
                    nf_now     = r_q.nf | v_noisy;
                    r_d.state  = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (rd_ack) begin
            r_d.full  = 1'b0;
            r_d.ovr   = 1'b0;
            r_d.noise = 1'b0;
            r_d.fe    = 1'b0;
        end
        if (accept) begin
            if (r_d.full) begin
                r_d.ovr = 1'b1;
            end else begin
                r_d.data  = frame_val;
                r_d.full  = 1'b1;
                r_d.noise = nf_now;
                r_d.fe    = fe_now;
            end
        end

        if (!rx_en) begin
            r_d.state = ST_IDLE;
            r_d.nf    = 1'b0;
            r_d.prev  = 1'b0;
            r_d.full  = 1'b0;
            r_d.ovr   = 1'b0;
            r_d.noise = 1'b0;
            r_d.fe    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pin_claim = rx_en;
    assign rx_data   = r_q.data;
    assign full      = r_q.full;
    assign overrun   = r_q.ovr;
    assign noise     = r_q.noise;
    assign frame_err = r_q.fe;
endmodule

// File: rtl/uart_wake_rx_chk.sv
module uart_wake_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rx_en,
    input logic            wake_req,
    input logic            wake_sel,
    input logic            rd_ack,
    input logic [DATA_W:0] rx_data,
    input logic            full,
    input logic            idle,
    input logic            overrun,
    input logic            noise,
    input logic            frame_err,
    input logic            sleeping
);
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!full && !idle && !overrun && !noise && !frame_err && !sleeping)); // R1

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && wake_req) |=> sleeping); // R3

    AST_ASLEEP_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && sleeping && !wake_sel && !full) |=> !full); // R6

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && full && !rd_ack) |=> $stable(rx_data)); // R10

    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !full && !overrun) |=> !overrun); // R10

    AST_FLAGS_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (noise || frame_err || overrun) |-> full); // R10

    AST_ACK_DROPS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rd_ack) |=> !overrun); // R11

    AST_IDLE_NOT_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && sleeping && !idle) |=> !idle); // R12
endmodule

bind uart_wake_rx uart_wake_rx_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_uart_wake_rx.sv
module test_uart_wake_rx;
    localparam int DATA_W = 8;
    localparam int OS     = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 1'b1;
    logic rx_in = 1'b1;
    logic rx_en = 1'b0;
    logic wake_req = 1'b0;
    logic wake_sel = 1'b0;
    logic len9 = 1'b0;
    logic rd_ack = 1'b0;
    logic pin_claim, full, idle, overrun, noise, frame_err, sleeping;
    logic [DATA_W:0] rx_data;

    always #4 clk = ~clk;

    uart_wake_rx #(.DATA_W(DATA_W), .OS_RATE(OS)) i_uart_wake_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in), .rx_en(rx_en),
        .wake_req(wake_req), .wake_sel(wake_sel), .len9(len9), .rd_ack(rd_ack),
        .pin_claim(pin_claim), .rx_data(rx_data), .full(full), .idle(idle),
        .overrun(overrun), .noise(noise), .frame_err(frame_err), .sleeping(sleeping)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [8:0] data;
        logic       nf;
        logic       fe;
    } exp_t;
    exp_t exp_q[$];

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ack();
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk) wake_req = 1'b1;
        @(negedge clk) wake_req = 1'b0;
    endtask

    // Driver: pushes the expected buffer contents, then drives the character.
    task automatic send(input logic [8:0] val, input int nbits, input logic stop,
                        input int glitch_bit, input bit load,
                        input logic exp_nf, input logic exp_fe);
        exp_t e;
        if (load) begin
            e.data = val;
            e.nf   = exp_nf;
            e.fe   = exp_fe;
            exp_q.push_back(e);
        end
        for (int b = 0; b < nbits + 2; b++) begin
            logic lvl;
            lvl = (b == 0) ? 1'b0 : ((b == nbits + 1) ? stop : val[b-1]);
            for (int o = 0; o < OS; o++) begin
                @(negedge clk);
                rx_in = (b == glitch_bit && o == 8) ? ~lvl : lvl;
            end
        end
        @(negedge clk) rx_in = 1'b1;
    endtask

    // Monitor: on each new load of the buffer, compare against the queue head.
    logic full_seen = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (full && !full_seen) begin
                if (exp_q.size() == 0) begin
                    total++;
                    bad++;
                    $display("FAIL R6 unexpected load actual=%0h expected=none", rx_data);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R7", "data", 32'(rx_data), 32'(e.data));
                    check("R8", "noise", 32'(noise), 32'(e.nf));
                    check("R9", "frame_err", 32'(frame_err), 32'(e.fe));
                end
            end
            full_seen = full;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        check("R1", "flags after reset", {26'd0, full, idle, overrun, noise, frame_err, sleeping}, 32'd0);
        check("R2", "pin_claim disabled", 32'(pin_claim), 32'd0);
        rx_en = 1'b1;
        cycles(5);
        check("R2", "pin_claim enabled", 32'(pin_claim), 32'd1);

        // R7: eight-bit character
        send(9'h0A5, 8, 1'b1, -1, 1'b1, 1'b0, 1'b0);
        cycles(4);
        check("R7", "full 8-bit", 32'(full), 32'd1);
        pulse_ack();
        check("R11", "full after ack", 32'(full), 32'd0);

        // R7: nine-bit character
        len9 = 1'b1;
        send(9'h1C3, 9, 1'b1, -1, 1'b1, 1'b0, 1'b0);
        cycles(4);
        check("R7", "full 9-bit", 32'(full), 32'd1);
        pulse_ack();
        len9 = 1'b0;

        // R8: one-cycle glitch at tick 9 of data bit 3
        send(9'h05A, 8, 1'b1, 4, 1'b1, 1'b1, 1'b0);
        cycles(4);
        check("R8", "noise set", 32'(noise), 32'd1);
        pulse_ack();
        check("R11", "noise after ack", 32'(noise), 32'd0);

        // R8: short low pulse is a false start
        @(negedge clk) rx_in = 1'b0;
        cycles(4);
        rx_in = 1'b1;
        cycles(300);
        check("R8", "false start dropped", 32'(full), 32'd0);

        // R9: stop bit low
        send(9'h033, 8, 1'b0, -1, 1'b1, 1'b0, 1'b1);
        cycles(4);
        check("R9", "frame_err set", 32'(frame_err), 32'd1);
        pulse_ack();
        cycles(300);
        check("R9", "no restart on low stop", 32'(full), 32'd0);
        check("R11", "frame_err after ack", 32'(frame_err), 32'd0);

        // R10: overrun keeps the older character
        send(9'h011, 8, 1'b1, -1, 1'b1, 1'b0, 1'b0);
        send(9'h022, 8, 1'b1, -1, 1'b0, 1'b0, 1'b0);
        cycles(4);
        check("R10", "overrun set", 32'(overrun), 32'd1);
        check("R10", "older data kept", 32'(rx_data), 32'h011);
        pulse_ack();
        check("R11", "overrun after ack", 32'(overrun), 32'd0);
        check("R11", "full after overrun ack", 32'(full), 32'd0);

        // R12: idle flag after a character
        send(9'h044, 8, 1'b1, -1, 1'b1, 1'b0, 1'b0);
        pulse_ack();
        check("R12", "idle not yet", 32'(idle), 32'd0);
        cycles(200);
        check("R12", "idle after quiet line", 32'(idle), 32'd1);
        send(9'h066, 8, 1'b1, -1, 1'b1, 1'b0, 1'b0);
        check("R12", "idle cleared by start", 32'(idle), 32'd0);
        pulse_ack();

        // R3 / R4: idle-line wake, 8-bit length
        wake_sel = 1'b0;
        pulse_wake();
        check("R3", "sleeping after request", 32'(sleeping), 32'd1);
        cycles(140);
        check("R4", "asleep before 160 ticks", 32'(sleeping), 32'd1);
        cycles(40);
        check("R4", "awake after 160 ticks", 32'(sleeping), 32'd0);

        // R4: idle-line wake, 9-bit length
        len9 = 1'b1;
        pulse_wake();
        cycles(165);
        check("R4", "asleep before 176 ticks", 32'(sleeping), 32'd1);
        cycles(30);
        check("R4", "awake after 176 ticks", 32'(sleeping), 32'd0);
        len9 = 1'b0;

        // R6: characters dropped while asleep
        pulse_wake();
        send(9'h055, 8, 1'b1, -1, 1'b0, 1'b0, 1'b0);
        cycles(4);
        check("R6", "no load while asleep", 32'(full), 32'd0);
        check("R6", "still asleep", 32'(sleeping), 32'd1);
        cycles(200);
        check("R4", "wake after trailing quiet", 32'(sleeping), 32'd0);
        send(9'h03C, 8, 1'b1, -1, 1'b1, 1'b0, 1'b0);
        cycles(4);
        check("R6", "load after wake", 32'(full), 32'd1);
        pulse_ack();

        // R5: address-mark wake, 8-bit
        wake_sel = 1'b1;
        pulse_wake();
        cycles(250);
        check("R4", "quiet line ignored in address mode", 32'(sleeping), 32'd1);
        send(9'h012, 8, 1'b1, -1, 1'b0, 1'b0, 1'b0);
        cycles(4);
        check("R5", "bit7 clear keeps sleep", 32'(sleeping), 32'd1);
        check("R6", "non-address dropped", 32'(full), 32'd0);
        send(9'h081, 8, 1'b1, -1, 1'b1, 1'b0, 1'b0);
        cycles(4);
        check("R5", "address wakes", 32'(sleeping), 32'd0);
        check("R5", "address loaded", 32'(rx_data), 32'h081);
        pulse_ack();

        // R5: address-mark wake, 9-bit uses bit 8
        len9 = 1'b1;
        pulse_wake();
        send(9'h0FF, 9, 1'b1, -1, 1'b0, 1'b0, 1'b0);
        cycles(4);
        check("R5", "bit8 clear keeps sleep", 32'(sleeping), 32'd1);
        send(9'h100, 9, 1'b1, -1, 1'b1, 1'b0, 1'b0);
        cycles(4);
        check("R5", "bit8 set wakes", 32'(sleeping), 32'd0);
        pulse_ack();
        len9 = 1'b0;

        // R1: disable clears flags and sleep
        wake_sel = 1'b0;
        send(9'h00F, 8, 1'b1, 1, 1'b1, 1'b1, 1'b0);
        cycles(4);
        wake_sel = 1'b1;
        pulse_wake();
        rx_en = 1'b0;
        cycles(2);
        check("R1", "flags while disabled", {26'd0, full, idle, overrun, noise, frame_err, sleeping}, 32'd0);
        check("R2", "pin released", 32'(pin_claim), 32'd0);
        send(9'h077, 8, 1'b1, -1, 1'b0, 1'b0, 1'b0);
        cycles(4);
        check("R1", "character ignored", 32'(full), 32'd0);
        pulse_wake();
        check("R1", "wake_req ignored", 32'(sleeping), 32'd0);
        rx_en = 1'b1;
        wake_sel = 1'b0;
        cycles(5);
        send(9'h069, 8, 1'b1, -1, 1'b1, 1'b0, 1'b0);
        cycles(4);
        check("R7", "load after re-enable", 32'(full), 32'd1);
        pulse_ack();
        cycles(4);

        check("R7", "pending expected loads", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule